// File: doc/BRIEF.md
# VME A32 Slave Handshake Controller

This block is the slave-side front end of a board sitting on a VMEbus backplane. The falling edge of the address strobe latches the address, the address modifier, the write line, the longword line and the interrupt-acknowledge line. The block compares the top five address bits with the board's slot number, taken from the active-low geographic pins. If they match, it runs a one-hot handshake machine. The machine has a shared decode trunk and two branches: one for single-word transfers and one for block transfers.

On a valid access the block drives a 16-bit internal address bus that carries address bits 17:2. In a block transfer the low eight bits of that bus come from a local word counter. The block then raises a request toward a secondary responder together with a write qualifier, and waits for the responder's acknowledge before it drives DTACK low. Accesses it does not accept are ignored: it drives neither DTACK nor a bus error.

Top module: `vme_a32_slave`

## Requirements
- R1: Address modifier 0x09 selects a single transfer and 0x0B selects a block transfer. Any other modifier on a board-selected cycle leaves dtack_n and req_n high for the whole cycle.
- R2: A cycle is accepted only with lword_n = 0, address bit 1 = 0 and iack_n = 1. Otherwise dtack_n and req_n stay high.
- R3: The board is selected only when address bits 31:27 equal the bitwise inverse of ga_n[4:0] (slot 5: ga_n = 11010, address bits 00101). On a mismatch the block stays idle: ibus_en, dtack_n and req_n do not change.
- R4: On a board-selected cycle with any of address bits 26:24 set, addr_err goes to 1 and the cycle is ignored. addr_err keeps its value until the next decoded cycle, which rewrites it.
- R5: Synchronous reset puts the machine in its idle state, with exactly one state flop set at all times. After reset, dtack_n = 1, req_n = 1, ibus_en = 0 and addr_err = 0.
- R6: The address strobe passes through two registers. The first negedge after the first clock edge that samples as_n low still shows ibus_en = 0. ibus_en is 1 after the third such edge when the board is selected.
- R7: A block transfer loads an 8-bit counter from address bits 9:2. The counter steps by one word per completed beat while the address strobe stays low, and wraps from 0xFF to 0x00 without changing bits 17:10.
- R8: When address bits 23:16 are 0x0F and bits 15:6 are zero (the configuration-write region), every beat of a block transfer carries the starting address.
- R9: After both data strobes are low, req_n goes low and wr_n follows the latched write line. dtack_n goes low only after a registered low on resp_ack_n, and returns high only after both data strobes are registered high.
- R10: ibus_en is 1 and ibus_addr carries address bits 17:2 (low byte from the counter during a block transfer) in every non-idle state. While idle, ibus_en is 0 and ibus_addr is high-impedance.
- R11: A block transfer loops for further beats while the address strobe stays low, and returns to idle once the address strobe is high after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 2 | Data strobes, active low, asynchronous |
| vme_addr | input | 31 | Address lines 31:1 |
| lword_n | input | 1 | Longword line, must be low |
| write_n | input | 1 | Write line, low for write |
| am | input | 6 | Address modifier |
| iack_n | input | 1 | Interrupt acknowledge, must be high |
| ga_n | input | 5 | Geographic address pins, active low |
| resp_ack_n | input | 1 | Acknowledge from secondary responder, active low |
| dtack_n | output | 1 | Data transfer acknowledge, active low |
| req_n | output | 1 | Request to secondary responder, active low |
| wr_n | output | 1 | Write qualifier to responder, low for write |
| ibus_en | output | 1 | High while ibus_addr is driven |
| ibus_addr | output | 16 | Internal address bits 17:2, high-impedance while idle |
| addr_err | output | 1 | Set when address bits 26:24 of a selected cycle are non-zero |

## Verification
Two events can land on the same clock edge. In a block transfer, the address strobe can rise in the same cycle that the responder releases its acknowledge. The machine must then choose between another beat and a return to idle, and it must not step the counter. The bench provokes this case by raising the strobe on the first negedge that shows DTACK high after the final beat. The bench checks that no further DTACK follows and that the bus floats. The other case is counter wrap against the held configuration address: both are judged beat by beat against addresses the bench computes from the start address.

// File: rtl/vme_slv_pkg.sv
package vme_slv_pkg;

    localparam int NST  = 9;
    localparam int S_DA = 0;
    localparam int S_DB = 1;
    localparam int S_SA = 2;
    localparam int S_SB = 3;
    localparam int S_SC = 4;
    localparam int S_BA = 5;
    localparam int S_BB = 6;
    localparam int S_BC = 7;
    localparam int S_BD = 8;

    typedef struct packed {
        logic [31:1] addr;
        logic        lw_n;
        logic        wr_n;
        logic [5:0]  am;
        logic        iack_n;
    } cap_t;

    typedef struct packed {
        logic sel;
        logic single;
        logic block;
        logic size_ok;
        logic yy_bad;
        logic cfg;
    } xfer_dec_t;

    typedef struct packed {
        logic [NST-1:0] st;
        logic           err;
    } fsm_reg_t;

    typedef struct packed {
        logic       as1;
        logic       as2;
        logic [1:0] ds;
        logic       ack;
        logic       det;
    } sync_reg_t;

endpackage

// File: rtl/vme_slv_capture.sv
module vme_slv_capture
    import vme_slv_pkg::*;
#(
    parameter int          GA_W      = 5,
    parameter int          IBUS_HI   = 17,
    parameter logic [5:0]  AM_SINGLE = 6'h09,
    parameter logic [5:0]  AM_BLOCK  = 6'h0B,
    parameter logic [7:0]  CFG_PAGE  = 8'h0F
) (
    input  logic                 as_n,
    input  logic [31:1]          vme_addr,
    input  logic                 lword_n,
    input  logic                 write_n,
    input  logic [5:0]           am,
    input  logic                 iack_n,
    input  logic [GA_W-1:0]      ga_n,
    output xfer_dec_t            dec,
    output logic [IBUS_HI-2:0]   base_ibus,
    output logic                 write_q
);
    localparam int GA_LO = 32 - GA_W;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.addr   = vme_addr;
        cap_d.lw_n   = lword_n;
        cap_d.wr_n   = write_n;
        cap_d.am     = am;
        cap_d.iack_n = iack_n;
    end

    // Address-phase latch, clocked by the strobe's falling edge
    always_ff @(negedge as_n) begin
        cap_q <= cap_d;
    end

    always_comb begin
        dec.sel     = (cap_q.addr[31:GA_LO] == ~ga_n);
        dec.single  = (cap_q.am == AM_SINGLE);
        dec.block   = (cap_q.am == AM_BLOCK);
        dec.size_ok = !cap_q.lw_n && !cap_q.addr[1] && cap_q.iack_n;
        dec.yy_bad  = |cap_q.addr[GA_LO-1:24];
        dec.cfg     = (cap_q.addr[23:16] == CFG_PAGE) && (cap_q.addr[15:6] == '0);
    end

    assign base_ibus = cap_q.addr[IBUS_HI:2];
    assign write_q   = cap_q.wr_n;

endmodule

// File: rtl/vme_slv_sync.sv
module vme_slv_sync
    import vme_slv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       as_n,
    input  logic [1:0] ds_n,
    input  logic       ack_n,
    input  logic       sel,
    input  logic       det_clr,
    output logic       as_s,
    output logic [1:0] ds_s,
    output logic       ack_s,
    output logic       det
);
    sync_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.as1 = as_n;
        r_d.as2 = r_q.as1;
        r_d.ds  = ds_n;
        r_d.ack = ack_n;
        if (det_clr)
            r_d.det = 1'b0;
        else if (r_q.as2 && !r_q.as1 && sel)
            r_d.det = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.as1 <= 1'b1;
            r_q.as2 <= 1'b1;
            r_q.ds  <= 2'b11;
            r_q.ack <= 1'b1;
            r_q.det <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign as_s  = r_q.as1;
    assign ds_s  = r_q.ds;
    assign ack_s = r_q.ack;
    assign det   = r_q.det;

    AST_DET_FROM_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(det) |-> $past(r_q.as2 && !r_q.as1)); // R6

endmodule

// File: rtl/vme_slv_blkcnt.sv
module vme_slv_blkcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             inc,
    input  logic             hold,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (inc && !hold)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !hold && !load) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R7
    AST_CNT_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        (inc && hold && !load) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/vme_slv_fsm.sv
module vme_slv_fsm
    import vme_slv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       det,
    input  logic       is_single,
    input  logic       is_block,
    input  logic       size_ok,
    input  logic       yy_bad,
    input  logic       as_s,
    input  logic [1:0] ds_s,
    input  logic       ack_s,
    output logic       det_clr,
    output logic       cnt_load,
    output logic       cnt_inc,
    output logic       req_n,
    output logic       dtack_n,
    output logic       bus_en,
    output logic       blk,
    output logic       addr_err
);
    fsm_reg_t cur, nx;
    logic     bad;

    always_comb begin
        nx     = cur;
        nx.st  = '0;
        bad    = !size_ok || yy_bad || !(is_single || is_block);

        if (cur.st[S_DA]) begin
            if (det) nx.st[S_DB] = 1'b1;
            else     nx.st[S_DA] = 1'b1;
        end
        if (cur.st[S_DB]) begin
            nx.err = yy_bad;
            if (bad)            nx.st[S_DA] = 1'b1;
            else if (is_single) nx.st[S_SA] = 1'b1;
            else                nx.st[S_BA] = 1'b1;
        end
        if (cur.st[S_SA]) begin
            if (as_s)                nx.st[S_DA] = 1'b1;
            else if (ds_s == 2'b00)  nx.st[S_SB] = 1'b1;
            else                     nx.st[S_SA] = 1'b1;
        end
        if (cur.st[S_SB]) begin
            if (!ack_s) nx.st[S_SC] = 1'b1;
            else        nx.st[S_SB] = 1'b1;
        end
        if (cur.st[S_SC]) begin
            if (ds_s == 2'b11) nx.st[S_DA] = 1'b1;
            else               nx.st[S_SC] = 1'b1;
        end
        if (cur.st[S_BA]) begin
            if (as_s)                nx.st[S_DA] = 1'b1;
            else if (ds_s == 2'b00)  nx.st[S_BB] = 1'b1;
            else                     nx.st[S_BA] = 1'b1;
        end
        if (cur.st[S_BB]) begin
            if (!ack_s) nx.st[S_BC] = 1'b1;
            else        nx.st[S_BB] = 1'b1;
        end
        if (cur.st[S_BC]) begin
            if (ds_s == 2'b11) nx.st[S_BD] = 1'b1;
            else               nx.st[S_BC] = 1'b1;
        end
        if (cur.st[S_BD]) begin
            if (!ack_s)    nx.st[S_BD] = 1'b1;
            else if (as_s) nx.st[S_DA] = 1'b1;
            else           nx.st[S_BA] = 1'b1;
        end
        if (cur.st == '0)
            nx.st[S_DA] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st       <= '0;
            cur.st[S_DA] <= 1'b1;
            cur.err      <= 1'b0;
        end else begin
            cur <= nx;
        end
    end

    assign det_clr  = cur.st[S_DB];
    assign cnt_load = cur.st[S_DB] && nx.st[S_BA];
    assign cnt_inc  = cur.st[S_BD] && nx.st[S_BA];
    assign req_n    = !(cur.st[S_SB] || cur.st[S_SC] || cur.st[S_BB] || cur.st[S_BC]);
    assign dtack_n  = !(cur.st[S_SC] || cur.st[S_BC]);
    assign bus_en   = !cur.st[S_DA];
    assign blk      = cur.st[S_BA] || cur.st[S_BB] || cur.st[S_BC] || cur.st[S_BD];
    assign addr_err = cur.err;

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
        $countones(cur.st) == 1); // R5
    AST_DTACK_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> !$past(ack_s)); // R9
    AST_DTACK_RELEASE_DS: assert property (@(posedge clk) disable iff (rst)
        $rose(dtack_n) |-> $past(ds_s) == 2'b11); // R9
    AST_BAD_HIGH_BITS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cur.st[S_DB] && yy_bad) |=> (cur.st[S_DA] && dtack_n && addr_err)); // R4

endmodule

// File: rtl/vme_a32_slave.sv
module vme_a32_slave
    import vme_slv_pkg::*;
#(
    parameter int          GA_W      = 5,
    parameter int          IBUS_HI   = 17,
    parameter int          CNT_W     = 8,
    parameter logic [5:0]  AM_SINGLE = 6'h09,
    parameter logic [5:0]  AM_BLOCK  = 6'h0B,
    parameter logic [7:0]  CFG_PAGE  = 8'h0F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                as_n,
    input  logic [1:0]          ds_n,
    input  logic [31:1]         vme_addr,
    input  logic                lword_n,
    input  logic                write_n,
    input  logic [5:0]          am,
    input  logic                iack_n,
    input  logic [GA_W-1:0]     ga_n,
    input  logic                resp_ack_n,
    output logic                dtack_n,
    output logic                req_n,
    output logic                wr_n,
    output logic                ibus_en,
    output logic [IBUS_HI-2:0]  ibus_addr,
    output logic                addr_err
);
    localparam int IBUS_W = IBUS_HI - 1;
    localparam int HI_W   = IBUS_W - CNT_W;

    xfer_dec_t          dec;
    logic [IBUS_W-1:0]  base_ibus;
    logic [IBUS_W-1:0]  bus_val;
    logic [CNT_W-1:0]   cnt;
    logic               write_q;
    logic               as_s, ack_s, det, det_clr;
    logic [1:0]         ds_s;
    logic               cnt_load, cnt_inc, blk, bus_en;

    vme_slv_capture #(
        .GA_W(GA_W), .IBUS_HI(IBUS_HI),
        .AM_SINGLE(AM_SINGLE), .AM_BLOCK(AM_BLOCK), .CFG_PAGE(CFG_PAGE)
    ) u_cap (
        .as_n(as_n), .vme_addr(vme_addr), .lword_n(lword_n), .write_n(write_n),
        .am(am), .iack_n(iack_n), .ga_n(ga_n),
        .dec(dec), .base_ibus(base_ibus), .write_q(write_q)
    );

    vme_slv_sync u_sync (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .ack_n(resp_ack_n),
        .sel(dec.sel), .det_clr(det_clr),
        .as_s(as_s), .ds_s(ds_s), .ack_s(ack_s), .det(det)
    );

    vme_slv_fsm u_fsm (
        .clk(clk), .rst(rst), .det(det),
        .is_single(dec.single), .is_block(dec.block),
        .size_ok(dec.size_ok), .yy_bad(dec.yy_bad),
        .as_s(as_s), .ds_s(ds_s), .ack_s(ack_s),
        .det_clr(det_clr), .cnt_load(cnt_load), .cnt_inc(cnt_inc),
        .req_n(req_n), .dtack_n(dtack_n), .bus_en(bus_en), .blk(blk),
        .addr_err(addr_err)
    );

    vme_slv_blkcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .inc(cnt_inc), .hold(dec.cfg),
        .load_val(base_ibus[CNT_W-1:0]), .cnt(cnt)
    );

    always_comb begin
        if (blk)
            bus_val = {base_ibus[IBUS_W-1:IBUS_W-HI_W], cnt};
        else
            bus_val = base_ibus;
    end

    assign ibus_addr = bus_en ? bus_val : 'z;
    assign ibus_en   = bus_en;
    assign wr_n      = write_q;

    AST_REQ_COVERS_DTACK: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> !req_n); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !ibus_en |-> (req_n && dtack_n)); // R10

endmodule

// File: tb/vme_a32_slave_tb.sv
module vme_a32_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RESP_DLY   = 2;
    localparam logic [4:0] SLOT_GA_N = 5'b11010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1;
    logic [1:0]  ds_n = 2'b11;
    logic [31:1] vme_addr = '0;
    logic        lword_n = 1'b0;
    logic        write_n = 1'b1;
    logic [5:0]  am = 6'h09;
    logic        iack_n = 1'b1;
    logic [4:0]  ga_n = SLOT_GA_N;
    logic        resp_ack_n = 1'b1;
    logic        dtack_n, req_n, wr_n, ibus_en, addr_err;
    logic [15:0] ibus_addr;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    int    ack_cnt  = 0;
    int    as_hi_cnt = 0;
    bit    quiet    = 1'b0;
    string quiet_tag = "";
    logic [15:0] exp_ibus = '0;
    logic        exp_wr   = 1'b1;

    vme_a32_slave u_dut (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .vme_addr(vme_addr),
        .lword_n(lword_n), .write_n(write_n), .am(am), .iack_n(iack_n),
        .ga_n(ga_n), .resp_ack_n(resp_ack_n), .dtack_n(dtack_n), .req_n(req_n),
        .wr_n(wr_n), .ibus_en(ibus_en), .ibus_addr(ibus_addr), .addr_err(addr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Responder: acknowledges RESP_DLY cycles after request, releases with it
    always @(negedge clk) begin
        if (req_n) begin
            ack_cnt    <= 0;
            resp_ack_n <= 1'b1;
        end else if (ack_cnt >= RESP_DLY) begin
            resp_ack_n <= 1'b0;
        end else begin
            ack_cnt <= ack_cnt + 1;
        end
    end

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (as_n) as_hi_cnt++; else as_hi_cnt = 0;
            if (quiet)
                chk(dtack_n && req_n, quiet_tag, {30'b0, dtack_n, req_n}, 32'h3);
            if (!dtack_n && !quiet) begin
                chk(ibus_en === 1'b1, "R10 bus driven during dtack", {31'b0, ibus_en}, 32'h1);
                chk(ibus_addr === exp_ibus, "R10 bus address", {16'b0, ibus_addr}, {16'b0, exp_ibus});
                chk(wr_n === exp_wr, "R9 write qualifier", {31'b0, wr_n}, {31'b0, exp_wr});
                chk(req_n === 1'b0, "R9 request held", {31'b0, req_n}, 32'h0);
            end
            if (as_hi_cnt >= 6)
                chk(ibus_en === 1'b0 && dtack_n === 1'b1, "R10 idle float",
                    {30'b0, ibus_en, dtack_n}, 32'h1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog expired actual %0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic wait_dtack(input logic v, input string tag);
        int n = 0;
        while (dtack_n !== v && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(dtack_n === v, tag, {31'b0, dtack_n}, {31'b0, v});
    endtask

    task automatic start_cycle(input logic [31:0] a, input logic [5:0] m, input logic rd,
                               input logic lw, input logic ik, input bit sel_exp, input string tag);
        @(negedge clk);
        vme_addr = a[31:1];
        am       = m;
        write_n  = rd;
        lword_n  = lw;
        iack_n   = ik;
        exp_wr   = rd;
        #1 as_n  = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(ibus_en === 1'b0, {tag, " R6 still idle after two edges"}, {31'b0, ibus_en}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk(ibus_en === sel_exp, {tag, " R6 R3 bus enable after third edge"},
            {31'b0, ibus_en}, {31'b0, sel_exp});
    endtask

    task automatic single_xfer(input logic [31:0] a, input logic [5:0] m, input logic rd,
                               input logic lw, input logic ik, input bit sel_exp,
                               input bit ok, input string tag);
        exp_ibus = a[17:2];
        if (!ok) begin
            quiet_tag = tag;
            quiet     = 1'b1;
        end
        start_cycle(a, m, rd, lw, ik, sel_exp, tag);
        ds_n = 2'b00;
        if (ok) begin
            wait_dtack(1'b0, {tag, " dtack asserted"});
            chk(ibus_addr === a[17:2], {tag, " R10 address 17:2"}, {16'b0, ibus_addr}, {16'b0, a[17:2]});
            @(negedge clk);
            ds_n = 2'b11;
            wait_dtack(1'b1, {tag, " R9 dtack released"});
            as_n = 1'b1;
        end else begin
            repeat (20) @(negedge clk);
            ds_n = 2'b11;
            as_n = 1'b1;
            repeat (6) @(negedge clk);
            quiet = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic block_xfer(input logic [31:0] a, input int beats, input bit cfg,
                              input logic rd, input string tag);
        logic [7:0] lo;
        start_cycle(a, 6'h0B, rd, 1'b0, 1'b1, 1'b1, tag);
        for (int i = 0; i < beats; i++) begin
            lo       = cfg ? a[9:2] : 8'(a[9:2] + i);
            exp_ibus = {a[17:10], lo};
            @(negedge clk);
            ds_n = 2'b00;
            wait_dtack(1'b0, {tag, " beat dtack"});
            chk(ibus_addr === {a[17:10], lo}, {tag, cfg ? " R8 held address" : " R7 stepped address"},
                {16'b0, ibus_addr}, {16'b0, a[17:10], lo});
            @(negedge clk);
            ds_n = 2'b11;
            wait_dtack(1'b1, {tag, " R9 beat release"});
            if (i == beats - 1) as_n = 1'b1;
        end
        repeat (4) @(negedge clk);
        chk(ibus_en === 1'b0, {tag, " R11 idle after strobe release"}, {31'b0, ibus_en}, 32'h0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(dtack_n === 1'b1 && req_n === 1'b1, "R5 reset handshake idle",
            {30'b0, dtack_n, req_n}, 32'h3);
        chk(ibus_en === 1'b0, "R5 reset bus off", {31'b0, ibus_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(addr_err === 1'b0, "R5 reset error flag", {31'b0, addr_err}, 32'h0);
        repeat (6) @(negedge clk);

        single_xfer(32'h2801_2344, 6'h09, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R1 single read");
        single_xfer(32'h2803_FFFC, 6'h09, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9 single write");
        single_xfer(32'h3001_2344, 6'h09, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 wrong slot");
        single_xfer(32'h2801_2344, 6'h0D, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R1 wrong modifier");
        single_xfer(32'h2801_2344, 6'h09, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 iack low");
        single_xfer(32'h2801_2344, 6'h09, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2 lword high");
        single_xfer(32'h2801_2346, 6'h09, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 address bit 1");
        single_xfer(32'h2901_2344, 6'h09, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 high bits set");
        chk(addr_err === 1'b1, "R4 error flag raised", {31'b0, addr_err}, 32'h1);

        block_xfer(32'h2800_4010, 4, 1'b0, 1'b1, "R7 block read");
        chk(addr_err === 1'b0, "R4 error flag cleared", {31'b0, addr_err}, 32'h0);
        block_xfer(32'h2800_47F8, 3, 1'b0, 1'b0, "R7 block wrap");
        block_xfer(32'h280F_0010, 3, 1'b1, 1'b0, "R8 config block");
        block_xfer(32'h2802_0100, 2, 1'b0, 1'b1, "R11 short block");
        single_xfer(32'h2800_0000, 6'h09, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R10 single after block");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule